// File: doc/BRIEF.md
# Microwire Serial EEPROM Responder

This block models a small serial EEPROM that holds a fixed set of 16-bit words. It does not have real serial pins. A host drives the chip-select, serial-clock and data-in lines by writing them into a control register, one pin state per write. The responder finds serial clock edges by comparing each written clock bit with the clock bit already stored. When the host reads the register, it gets back the stored pin states, two status bits that are always set, and the current data-out bit.

After a rising clock edge with chip-select high, the responder samples data-in. The first nine bits it collects form a 3-bit opcode followed by a 6-bit word address, each sent most-significant bit first. The read opcode loads an output bit pointer with the position one bit before the addressed word. Each falling clock edge then advances the pointer, so the word comes out MSB first. If the host keeps clocking, the stream continues into the following words and wraps from the last word back to word 0. A rising clock edge while chip-select is low clears the whole protocol state.

Top module: `mw_eeprom_resp`

## Requirements
- R1: After reset, `rd_data` reads 6'b111000: all three pin bits are 0, data-out is 1, and both status bits are 1.
- R2: `rd_data[2:0]` reflects the pin bits of the most recent write, with clock in bit 0, chip-select in bit 1 and data-in in bit 2. `rd_data[4]` (present) and `rd_data[5]` (granted) always read 1. `rd_data[3]` is data-out.
- R3: A write whose clock bit equals the stored clock bit changes only the stored pins. Changes to chip-select or data-in in such a write do not shift, reset or move the output stream.
- R4: A rising clock edge with chip-select low clears the input shift state, both bit counters and the reading flag. After it, data-out reads 1 until a new read command completes.
- R5: On the ninth rising clock edge with chip-select high after a clear, the first three bits collected are taken as the opcode and the last six as the word address. Opcode 3'b110 starts a read.
- R6: While no read is active, data-out reads 1. This includes any opcode other than 3'b110, however long the host keeps clocking afterwards.
- R7: After the ninth rising edge, each falling clock edge presents the next bit of the addressed word, from bit 15 down to bit 0.
- R8: Clocking past bit 0 of a word continues with bit 15 of the next word. The stream wraps from word 63 to word 0.
- R9: After reset, word i holds (16'hA1E7 + i*16'h3C5B) mod 2^16.
- R10: Once a read is active, further rising edges with chip-select high do not disturb the output stream.
- R11: Between the ninth rising edge and the next falling edge, data-out shows bit 0 of the word before the addressed one. For address 0 that is word 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 3 | Pin states to store: {data-in, chip-select, serial clock} |
| rd_data | output | 6 | {granted, present, data-out, data-in, chip-select, serial clock} |

## Verification
The hardest state to observe is the one-bit window right after the ninth rising edge. There the output pointer sits one position before the addressed word and shows the last bit of the previous word. For address 0, that bit comes from word 63 through counter wrap. The bench samples data-out in that window for every command in its vector table, then sends a long read starting at word 63 so the stream crosses the wrap. Separate directed sequences toggle chip-select and data-in while the clock bit is held, and deselect in the middle of a stream, to show which writes count as edges and which do not.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

   // Bit positions of the host-visible register.
   localparam int PIN_CLK  = 0;
   localparam int PIN_SEL  = 1;
   localparam int PIN_DIN  = 2;
   localparam int PIN_DOUT = 3;
   localparam int PIN_PRES = 4;
   localparam int PIN_GNT  = 5;
   localparam int PIN_W    = 3;
   localparam int REG_W    = 6;

   typedef struct packed {
      logic din;
      logic sel;
      logic clk;
   } pins_t;

   typedef enum logic [1:0] {
      EV_NONE,
      EV_FALL,
      EV_RISE_IDLE,
      EV_RISE_SEL
   } edge_ev_t;

endpackage

// File: rtl/mw_pin_latch.sv
module mw_pin_latch
   import mw_eeprom_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  pins_t    wr_pins,
   output pins_t    pins_q,
   output edge_ev_t ev
);

   // Classify the serial clock event carried by this write.
   always_comb begin
      ev = EV_NONE;
      if (wr_en && (wr_pins.clk != pins_q.clk)) begin
         if (!wr_pins.clk)
            ev = EV_FALL;
         else if (wr_pins.sel)
            ev = EV_RISE_SEL;
         else
            ev = EV_RISE_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pins_q <= '0;
      else if (wr_en)
         pins_q <= wr_pins;
   end

   assert_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (pins_q == $past(wr_pins)));

endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
   import mw_eeprom_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BIT_W  = 4,
   parameter int OP_W   = 3,
   parameter logic [OP_W-1:0] READ_OP = 3'b110,
   localparam int CMD_W = ADDR_W + OP_W,
   localparam int CNT_W = ADDR_W + BIT_W,
   localparam int IN_W  = $clog2(CMD_W) + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  edge_ev_t         ev,
   input  logic             din,
   output logic [CNT_W-1:0] out_cnt,
   output logic             reading
);

   localparam logic [IN_W-1:0] IN_MAX  = '1;
   localparam logic [IN_W-1:0] IN_DONE = IN_W'(CMD_W);

   logic [CMD_W-2:0] shift_q;
   logic [CMD_W-1:0] shift_nx;
   logic [IN_W-1:0]  in_cnt;
   logic [IN_W-1:0]  in_nx;
   logic             cmd_done;

   assign shift_nx = {shift_q, din};
   // Saturate so a finished non-read command can never decode again.
   assign in_nx    = (in_cnt == IN_MAX) ? in_cnt : in_cnt + 1'b1;
   assign cmd_done = (in_nx == IN_DONE) && !reading;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         in_cnt  <= '0;
         out_cnt <= '0;
         reading <= 1'b0;
      end else begin
         unique case (ev)
            EV_FALL: out_cnt <= out_cnt + 1'b1;
            EV_RISE_IDLE: begin
               shift_q <= '0;
               in_cnt  <= '0;
               out_cnt <= '0;
               reading <= 1'b0;
            end
            EV_RISE_SEL: begin
               shift_q <= shift_nx[CMD_W-2:0];
               in_cnt  <= in_nx;
               if (cmd_done) begin
                  out_cnt <= {shift_nx[ADDR_W-1:0], {BIT_W{1'b0}}} - 1'b1;
                  reading <= (shift_nx[CMD_W-1 -: OP_W] == READ_OP);
               end
            end
            default: ;
         endcase
      end
   end

   assert_steady_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_NONE) |=> ($stable(out_cnt) && $stable(reading) && $stable(in_cnt)));

   assert_deselect_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_RISE_IDLE) |=> (!reading && (in_cnt == '0) && (out_cnt == '0)));

   assert_fall_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_FALL) |=> (out_cnt == $past(out_cnt) + 1'b1));

   assert_read_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reading && ev == EV_RISE_SEL) |=> ($stable(out_cnt) && reading));

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
   parameter int WORDS  = 64,
   parameter int WORD_W = 16,
   parameter logic [WORD_W-1:0] INIT_SEED = 16'hA1E7,
   parameter logic [WORD_W-1:0] INIT_STEP = 16'h3C5B,
   parameter bit MSB_FIRST = 1'b1,
   localparam int ADDR_W = $clog2(WORDS),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int CNT_W  = ADDR_W + BIT_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rd_cnt,
   input  logic             reading,
   output logic             dout
);

   logic [WORD_W-1:0] mem [WORDS];
   logic [ADDR_W-1:0] word_sel;
   logic [BIT_W-1:0]  bit_sel;
   logic [WORD_W-1:0] cur;
   logic              bit_val;

   function automatic logic [WORD_W-1:0] init_word(input int idx);
      return INIT_SEED + WORD_W'(idx) * INIT_STEP;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++)
            mem[w] <= init_word(w);
      end
   end

   assign word_sel = rd_cnt[CNT_W-1 -: ADDR_W];
   assign bit_sel  = rd_cnt[BIT_W-1:0];
   assign cur      = mem[word_sel];

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_val = cur[~bit_sel];
      end else begin : g_lsb
         assign bit_val = cur[bit_sel];
      end
   endgenerate

   assign dout = reading ? bit_val : 1'b1;

   assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !reading |-> dout);

endmodule

// File: rtl/mw_eeprom_resp.sv
module mw_eeprom_resp
   import mw_eeprom_pkg::*;
#(
   parameter int WORDS  = 64,
   parameter int WORD_W = 16,
   parameter int OP_W   = 3,
   parameter logic [OP_W-1:0]   READ_OP   = 3'b110,
   parameter logic [WORD_W-1:0] INIT_SEED = 16'hA1E7,
   parameter logic [WORD_W-1:0] INIT_STEP = 16'h3C5B,
   localparam int ADDR_W = $clog2(WORDS),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int CNT_W  = ADDR_W + BIT_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PIN_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data
);

   generate
      if ((WORDS & (WORDS - 1)) != 0 || WORDS < 2) begin : g_bad_words
         $error("WORDS must be a power of two of at least 2");
      end
      if ((WORD_W & (WORD_W - 1)) != 0 || WORD_W < 2) begin : g_bad_width
         $error("WORD_W must be a power of two of at least 2");
      end
      if (OP_W < 1) begin : g_bad_op
         $error("OP_W must be at least 1");
      end
   endgenerate

   pins_t            pins_q;
   edge_ev_t         ev;
   logic [CNT_W-1:0] out_cnt;
   logic             reading;
   logic             dout;

   mw_pin_latch i_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_pins (pins_t'(wr_data)),
      .pins_q  (pins_q),
      .ev      (ev)
   );

   mw_cmd_engine #(
      .ADDR_W  (ADDR_W),
      .BIT_W   (BIT_W),
      .OP_W    (OP_W),
      .READ_OP (READ_OP)
   ) i_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .din     (wr_data[PIN_DIN]),
      .out_cnt (out_cnt),
      .reading (reading)
   );

   mw_word_store #(
      .WORDS     (WORDS),
      .WORD_W    (WORD_W),
      .INIT_SEED (INIT_SEED),
      .INIT_STEP (INIT_STEP),
      .MSB_FIRST (1'b1)
   ) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_cnt  (out_cnt),
      .reading (reading),
      .dout    (dout)
   );

   always_comb begin
      rd_data           = '0;
      rd_data[PIN_CLK]  = pins_q.clk;
      rd_data[PIN_SEL]  = pins_q.sel;
      rd_data[PIN_DIN]  = pins_q.din;
      rd_data[PIN_DOUT] = dout;
      rd_data[PIN_PRES] = 1'b1;
      rd_data[PIN_GNT]  = 1'b1;
   end

endmodule

// File: tb/test_mw_eeprom_resp.sv
module test_mw_eeprom_resp;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_data = '0;
   logic [5:0] rd_data;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   mw_eeprom_resp i_mw_eeprom_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   // {opcode[2:0], address[5:0], bits to stream[6:0]}
   localparam logic [15:0] VEC [6] = '{
      {3'b110, 6'd5,  7'd16},
      {3'b110, 6'd63, 7'd40},
      {3'b110, 6'd0,  7'd20},
      {3'b101, 6'd7,  7'd40},
      {3'b110, 6'd33, 7'd48},
      {3'b011, 6'd12, 7'd8}
   };

   function automatic logic [15:0] word_at(input int idx);
      logic [31:0] t;
      t = 32'(idx) * 32'h3C5B + 32'hA1E7;
      return t[15:0];
   endfunction

   function automatic logic stream_bit(input int addr, input int k);
      logic [9:0]  c;
      logic [15:0] w;
      c = 10'(addr * 16 + k);
      w = word_at(int'(c[9:4]));
      return w[15 - int'(c[3:0])];
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic din, input logic sel, input logic sck);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = {din, sel, sck};
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic deselect();
      put(1'b0, 1'b0, 1'b0);
      put(1'b0, 1'b0, 1'b1);
      put(1'b0, 1'b0, 1'b0);
   endtask

   task automatic send_cmd(input logic [2:0] op, input logic [5:0] addr);
      logic [8:0] cmd;
      cmd = {op, addr};
      for (int i = 8; i >= 0; i--) begin
         put(cmd[i], 1'b1, 1'b0);
         put(cmd[i], 1'b1, 1'b1);
      end
   endtask

   // Each bit: falling edge, sample, then a rising edge with select high (R10).
   task automatic stream(input int addr, input int n, input bit is_read, input string req);
      for (int k = 0; k < n; k++) begin
         put(1'b0, 1'b1, 1'b0);
         check(req, 16'(rd_data[3]), is_read ? 16'(stream_bit(addr, k)) : 16'd1);
         put(1'b1, 1'b1, 1'b1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset value", 16'(rd_data), 16'h0038);

      // R2: pin echo and status bits
      put(1'b1, 1'b0, 1'b0);
      check("R2 echo", 16'(rd_data), 16'h003C);

      // Vector table: R5, R6, R7, R8, R9, R10, R11
      for (int v = 0; v < 6; v++) begin
         logic [2:0] op;
         logic [5:0] ad;
         int         n;
         bit         rd;
         logic [15:0] prev;
         op = VEC[v][15:13];
         ad = VEC[v][12:7];
         n  = int'(VEC[v][6:0]);
         rd = (op == 3'b110);
         deselect();
         send_cmd(op, ad);
         prev = word_at((int'(ad) + 63) % 64);
         check("R11 preload", 16'(rd_data[3]), rd ? 16'(prev[0]) : 16'd1);
         stream(int'(ad), n, rd, rd ? "R7/R8/R9 stream" : "R6 idle high");
      end

      // R3: select dropped and data-in flipped while clock held high mid-command
      deselect();
      begin
         logic [8:0] cmd;
         cmd = {3'b110, 6'd9};
         for (int i = 8; i >= 0; i--) begin
            put(cmd[i], 1'b1, 1'b0);
            put(cmd[i], 1'b1, 1'b1);
            if (i == 5) begin
               put(~cmd[i], 1'b0, 1'b1);
               check("R2 echo steady clock", 16'(rd_data[2:0]), 16'({~cmd[i], 2'b01}));
               put(cmd[i], 1'b1, 1'b1);
            end
         end
      end
      stream(9, 16, 1'b1, "R3 no effect");

      // R4: deselect part-way through a stream
      deselect();
      send_cmd(3'b110, 6'd20);
      stream(20, 5, 1'b1, "R7 word 20");
      put(1'b0, 1'b1, 1'b0);
      check("R7 bit 5", 16'(rd_data[3]), 16'(stream_bit(20, 5)));
      put(1'b1, 1'b0, 1'b0);
      check("R3 select low clock steady", 16'(rd_data[3]), 16'(stream_bit(20, 5)));
      put(1'b1, 1'b0, 1'b1);
      check("R4 clear", 16'(rd_data), 16'h003D);
      put(1'b0, 1'b0, 1'b0);
      check("R4 stays idle", 16'(rd_data[3]), 16'd1);
      send_cmd(3'b110, 6'd2);
      stream(2, 16, 1'b1, "R4 fresh command");

      // R1 again: reset in the middle of a read
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset mid read", 16'(rd_data), 16'h0038);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule